// File: doc/BRIEF.md
# Ethernet MAC Line Configuration Register

This block holds the line configuration word of a 10 Mb/s Ethernet MAC. A host writes and reads it over a simple strobe-based register bus. The stored bits drive the receive and transmit enable gates, the choice of physical attachment (attachment-unit port, twisted pair, or automatic choice), and four mode flags. Those flags select modified backoff, turn off two-part deferral, turn off receive polarity correction, and lower the receive squelch thresholds.

Every write carries a six-bit register identity in its low bits. A write whose identity does not match is dropped. The receive and transmit enables are applied only at packet boundaries. While the matching datapath reports a packet in flight, the effective enable keeps its previous value, so turning a path off never cuts a frame short. When twisted pair is the active attachment, the transmit enable is also held off until link pulses have been seen or link testing has been switched off externally.

Top module: `mac_line_ctrl`

## Requirements
- R1: After synchronous reset, a read returns 0x0013. rx_enable, tx_enable, sel_aui, mod_backoff, defer_single, polarity_hold and lo_squelch are all 0.
- R2: A write whose bits 5..0 equal 6'b010011 (bit 0 is the LSB) stores bits 14..11 and 9..6 of wr_data. Bits 15 and 10 always read as 0.
- R3: A write whose bits 5..0 differ from 6'b010011 changes no stored bit and no output.
- R4: rd_data is loaded on the clock edge where rd_en is high, and shows the stored bits before any write in that same cycle, with bits 5..0 forced to 6'b010011. It holds its value while rd_en is low.
- R5: On each clock edge where rx_busy is low, rx_enable takes stored bit 6. While rx_busy is high, rx_enable keeps its value.
- R6: On each clock edge where tx_busy is low, the internal transmit gate takes stored bit 7. While tx_busy is high, it keeps its value. tx_enable equals that gate, further qualified as in R8.
- R7: sel_aui is 1 when stored bit 8 is 1, whatever bit 9 holds. It is 0 when bits 8 and 9 are both 0. When bit 8 is 0 and bit 9 is 1, sel_aui follows the auto_pick_aui input, where 1 means attachment-unit port.
- R8: While sel_aui is 0, tx_enable is 0 unless link_seen or link_test_off is 1.
- R9: mod_backoff, polarity_hold, defer_single and lo_squelch show stored bits 11, 12, 13 and 14 respectively, starting in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 16 | Host write data, identity in bits 5..0 |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 16 | Registered read data |
| rx_busy | input | 1 | Receive path has a frame in progress |
| tx_busy | input | 1 | Transmit path has a frame in progress |
| link_seen | input | 1 | Twisted-pair link pulses detected |
| link_test_off | input | 1 | Link testing disabled externally |
| auto_pick_aui | input | 1 | Automatic attachment result, 1 = attachment-unit port |
| rx_enable | output | 1 | Effective receive enable |
| tx_enable | output | 1 | Effective transmit enable |
| sel_aui | output | 1 | 1 = attachment-unit port, 0 = twisted pair |
| mod_backoff | output | 1 | Modified backoff selected |
| polarity_hold | output | 1 | Receive polarity correction disabled |
| defer_single | output | 1 | Two-part deferral disabled |
| lo_squelch | output | 1 | Reduced squelch thresholds |

## Verification
Random writes mix matching and non-matching identities, so a stored value that moves after a foreign write shows up as an accept/reject fault rather than a data fault. The busy inputs toggle on their own against enable changes. That separates an enable that waits for the packet boundary from one that follows the register straight away, and it shows a mix-up between the receive and transmit busy signals. Link, link-test and auto-pick inputs are drawn freely over all three attachment codes, which exposes a wrong priority between bits 8 and 9 and a missing link qualification. Directed cases cover the reset word, an all-ones word with a bad identity, and an all-ones word with a good identity.

// File: rtl/lctl_pkg.sv
package lctl_pkg;

    localparam int REG_W = 16;
    localparam int ID_W  = 6;
    localparam logic [ID_W-1:0] LCTL_ID = 6'b010011;

    localparam int POS_RX   = 6;
    localparam int POS_TX   = 7;
    localparam int POS_AUI  = 8;
    localparam int POS_AUTO = 9;
    localparam int POS_BOFF = 11;
    localparam int POS_POL  = 12;
    localparam int POS_DEF  = 13;
    localparam int POS_SQL  = 14;

    typedef struct packed {
        logic lo_squelch;
        logic defer_single;
        logic polarity_hold;
        logic mod_backoff;
        logic auto_sel;
        logic aui_only;
        logic tx_on;
        logic rx_on;
    } lctl_cfg_t;

    typedef enum logic [1:0] {
        IF_TP   = 2'd0,
        IF_AUI  = 2'd1,
        IF_AUTO = 2'd2
    } lctl_if_t;

    localparam lctl_cfg_t CFG_RESET = '0;

    function automatic lctl_cfg_t word_to_cfg(input logic [REG_W-1:0] w);
        lctl_cfg_t c;
        c.rx_on         = w[POS_RX];
        c.tx_on         = w[POS_TX];
        c.aui_only      = w[POS_AUI];
        c.auto_sel      = w[POS_AUTO];
        c.mod_backoff   = w[POS_BOFF];
        c.polarity_hold = w[POS_POL];
        c.defer_single  = w[POS_DEF];
        c.lo_squelch    = w[POS_SQL];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] cfg_to_word(input lctl_cfg_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[ID_W-1:0] = LCTL_ID;
        w[POS_RX]   = c.rx_on;
        w[POS_TX]   = c.tx_on;
        w[POS_AUI]  = c.aui_only;
        w[POS_AUTO] = c.auto_sel;
        w[POS_BOFF] = c.mod_backoff;
        w[POS_POL]  = c.polarity_hold;
        w[POS_DEF]  = c.defer_single;
        w[POS_SQL]  = c.lo_squelch;
        return w;
    endfunction

    function automatic lctl_if_t decode_if(input logic aui_only, input logic auto_sel);
        if (aui_only)
            return IF_AUI;
        else if (auto_sel)
            return IF_AUTO;
        else
            return IF_TP;
    endfunction

endpackage

// File: rtl/lctl_regfile.sv
module lctl_regfile
    import lctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_en,
    output logic [REG_W-1:0] rd_data,
    output lctl_cfg_t        cfg
);

    logic id_hit;
    logic unused_bits;

    assign id_hit      = (wr_data[ID_W-1:0] == LCTL_ID);
    assign unused_bits = &{1'b0, wr_data[REG_W-1], wr_data[10]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (wr_en && id_hit) begin
            cfg <= word_to_cfg(wr_data);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= cfg_to_word(cfg);
        end
    end

    // R3
    bad_id_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !id_hit) |=> $stable(cfg));

    // R4
    read_id_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (rd_data[ID_W-1:0] == LCTL_ID));

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (rd_data[REG_W-1] == 1'b0 && rd_data[10] == 1'b0));

    // R4
    read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/lctl_gate.sv
module lctl_gate (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic req,
    output logic gate
);

    always_ff @(posedge clk) begin
        if (rst) begin
            gate <= 1'b0;
        end else if (!busy) begin
            gate <= req;
        end
    end

    // R5
    hold_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(gate));

    // R6
    follow_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |=> (gate == $past(req)));

endmodule

// File: rtl/lctl_ifsel.sv
module lctl_ifsel
    import lctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic aui_only,
    input  logic auto_sel,
    input  logic auto_pick_aui,
    input  logic link_seen,
    input  logic link_test_off,
    input  logic tx_gate,
    output logic sel_aui,
    output logic tx_enable
);

    lctl_if_t mode;
    logic     tp_link_ok;

    assign mode = decode_if(aui_only, auto_sel);

    always_comb begin
        unique case (mode)
            IF_AUI:  sel_aui = 1'b1;
            IF_AUTO: sel_aui = auto_pick_aui;
            default: sel_aui = 1'b0;
        endcase
    end

    assign tp_link_ok = link_seen | link_test_off;
    assign tx_enable  = tx_gate & (sel_aui | tp_link_ok);

    // R7
    aui_priority_chk: assert property (@(posedge clk) disable iff (rst)
        aui_only |-> sel_aui);

    // R7
    tp_select_chk: assert property (@(posedge clk) disable iff (rst)
        (!aui_only && !auto_sel) |-> !sel_aui);

    // R8
    no_link_no_tx_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel_aui && !link_seen && !link_test_off) |-> !tx_enable);

endmodule

// File: rtl/mac_line_ctrl.sv
module mac_line_ctrl
    import lctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    input  logic        rd_en,
    output logic [15:0] rd_data,
    input  logic        rx_busy,
    input  logic        tx_busy,
    input  logic        link_seen,
    input  logic        link_test_off,
    input  logic        auto_pick_aui,
    output logic        rx_enable,
    output logic        tx_enable,
    output logic        sel_aui,
    output logic        mod_backoff,
    output logic        polarity_hold,
    output logic        defer_single,
    output logic        lo_squelch
);

    localparam int N_PATH = 2;

    lctl_cfg_t         cfg;
    logic [N_PATH-1:0] busy_vec;
    logic [N_PATH-1:0] req_vec;
    logic [N_PATH-1:0] gate_vec;

    lctl_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .cfg     (cfg)
    );

    assign busy_vec = {tx_busy, rx_busy};
    assign req_vec  = {cfg.tx_on, cfg.rx_on};

    for (genvar p = 0; p < N_PATH; p++) begin : g_path
        lctl_gate u_gate (
            .clk  (clk),
            .rst  (rst),
            .busy (busy_vec[p]),
            .req  (req_vec[p]),
            .gate (gate_vec[p])
        );
    end

    lctl_ifsel u_ifsel (
        .clk           (clk),
        .rst           (rst),
        .aui_only      (cfg.aui_only),
        .auto_sel      (cfg.auto_sel),
        .auto_pick_aui (auto_pick_aui),
        .link_seen     (link_seen),
        .link_test_off (link_test_off),
        .tx_gate       (gate_vec[1]),
        .sel_aui       (sel_aui),
        .tx_enable     (tx_enable)
    );

    assign rx_enable     = gate_vec[0];
    assign mod_backoff   = cfg.mod_backoff;
    assign polarity_hold = cfg.polarity_hold;
    assign defer_single  = cfg.defer_single;
    assign lo_squelch    = cfg.lo_squelch;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rx_enable && !tx_enable && !mod_backoff && !lo_squelch));

    // R5
    rx_hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rx_busy |=> $stable(rx_enable));

endmodule

// File: tb/tb_mac_line_ctrl.sv
`timescale 1ns/1ps
module tb_mac_line_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        rx_busy = 1'b0;
    logic        tx_busy = 1'b0;
    logic        link_seen = 1'b0;
    logic        link_test_off = 1'b0;
    logic        auto_pick_aui = 1'b0;
    logic        rx_enable, tx_enable, sel_aui;
    logic        mod_backoff, polarity_hold, defer_single, lo_squelch;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [15:0] m_cfg;
    logic        m_rx, m_tx;
    logic [15:0] m_rd;

    always #2 clk = ~clk;

    mac_line_ctrl dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rx_busy(rx_busy), .tx_busy(tx_busy),
        .link_seen(link_seen), .link_test_off(link_test_off),
        .auto_pick_aui(auto_pick_aui), .rx_enable(rx_enable), .tx_enable(tx_enable),
        .sel_aui(sel_aui), .mod_backoff(mod_backoff), .polarity_hold(polarity_hold),
        .defer_single(defer_single), .lo_squelch(lo_squelch)
    );

    function automatic logic exp_sel(input logic [15:0] c, input logic ap);
        return c[8] | (c[9] & ap);
    endfunction

    function automatic logic exp_txen(input logic [15:0] c, input logic g,
                                      input logic ap, input logic ls, input logic lt);
        return g & (exp_sel(c, ap) | ls | lt);
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        check("R4 rd_data", rd_data, m_rd);
        check("R5 rx_enable", {15'd0, rx_enable}, {15'd0, m_rx});
        check("R6/R8 tx_enable", {15'd0, tx_enable},
              {15'd0, exp_txen(m_cfg, m_tx, auto_pick_aui, link_seen, link_test_off)});
        check("R7 sel_aui", {15'd0, sel_aui}, {15'd0, exp_sel(m_cfg, auto_pick_aui)});
        check("R9 mode flags", {12'd0, lo_squelch, defer_single, polarity_hold, mod_backoff},
              {12'd0, m_cfg[14:11]});
    endtask

    task automatic step(input logic w, input logic [15:0] d, input logic r,
                        input logic rb, input logic tb, input logic ls,
                        input logic lt, input logic ap);
        logic [15:0] oc;
        wr_en = w; wr_data = d; rd_en = r; rx_busy = rb; tx_busy = tb;
        link_seen = ls; link_test_off = lt; auto_pick_aui = ap;
        @(posedge clk);
        oc = m_cfg;
        if (!rb) m_rx = oc[6];
        if (!tb) m_tx = oc[7];
        if (r) m_rd = oc | 16'h0013;
        if (w && d[5:0] == 6'b010011) m_cfg = d & 16'h7BC0;
        @(negedge clk);
        check_all();
    endtask

    task automatic idle_read();
        step(1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_cfg = '0; m_rx = 0; m_tx = 0; m_rd = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 outputs after reset", {9'd0, rx_enable, tx_enable, sel_aui,
              mod_backoff, polarity_hold, defer_single, lo_squelch}, 16'h0000);
        idle_read();
        check("R1 reset read word", rd_data, 16'h0013);

        // R3: all-ones with wrong identity is dropped
        step(1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        idle_read();
        check("R3 bad id ignored", rd_data, 16'h0013);

        // R2: all-ones with good identity, reserved bits read 0
        step(1'b1, 16'hFFD3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        idle_read();
        check("R2 good id stored", rd_data, 16'h7BD3);

        // R5/R6: clearing enables while busy holds them until idle
        step(1'b1, 16'h0013, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R5 rx held while busy", {15'd0, rx_enable}, 16'h0001);
        check("R6 tx held while busy", {15'd0, tx_enable}, 16'h0001);
        step(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R5 rx off after idle", {15'd0, rx_enable}, 16'h0000);

        // R8: twisted pair with tx on, no link
        step(1'b1, 16'h00D3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R8 tx blocked without link", {15'd0, tx_enable}, 16'h0000);
        step(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R8 tx allowed with link test off", {15'd0, tx_enable}, 16'h0001);

        // R7: auto mode follows auto_pick_aui; bit 8 wins
        step(1'b1, 16'h0213, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R7 auto picks aui", {15'd0, sel_aui}, 16'h0001);
        step(1'b1, 16'h0313, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R7 aui bit has priority", {15'd0, sel_aui}, 16'h0001);

        for (int i = 0; i < 3000; i++) begin
            logic w, ok;
            logic [15:0] d;
            w  = ($urandom % 4) == 0;
            ok = ($urandom % 4) != 0;
            d  = 16'($urandom);
            if (ok) d[5:0] = 6'b010011;
            step(w, d, ($urandom % 3) == 0, ($urandom % 2) == 0, ($urandom % 2) == 0,
                 ($urandom % 3) == 0, ($urandom % 5) == 0, ($urandom % 2) == 0);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule